// File: doc/BRIEF.md
# Two-Stage I2C Bit-Rate Tick Generator

This block turns a fast peripheral clock into the quarter-bit timing strobes that an I2C bit engine needs to shape SCL and to place SDA changes. The rate comes from one 8-bit control byte that holds two fields. A small prescaler divides the input clock by 1 to 4 and forms an internal clock-enable. A second counter then counts internal-clock steps to build one SCL period of `8*SCGD + 20` steps. The bit engine that consumes the strobes, and the choice of the control byte for a wanted frequency, are outside this block.

Each SCL period is cut into four equal quarters. The period length is always a multiple of four, so every quarter lasts exactly `2*SCGD + 5` internal steps. A one-cycle strobe marks the start of each quarter, and the strobes come out in a fixed rotation. Any write of the control byte restarts both counters from zero, and so does a low enable. The first strobe after a restart therefore always opens a fresh period.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted, and afterwards for as long as `enable` stays low, `phase_tick` is all zeros.
- R2: The control byte carries the prescale select in bits [1:0] (called CDF) and the period select in bits [7:2] (called SCGD). It is captured on a rising edge where `cfg_wr` is high and governs timing from the next cycle.
- R3: With `enable` held high and no write, consecutive `phase_tick[0]` pulses are exactly `(8*SCGD + 20) * (CDF + 1)` clock cycles apart.
- R4: Each period has four one-cycle strobes, in the order `phase_tick[0]`, `[1]`, `[2]`, `[3]`, then `[0]` again. Consecutive strobes are exactly `(2*SCGD + 5) * (CDF + 1)` cycles apart.
- R5: At most one bit of `phase_tick` is high in any cycle.
- R6: While `enable` is low, both counters stay cleared and no strobe appears. When `enable` is first sampled high on rising edge E, the first strobe is `phase_tick[0]` and is driven after edge E + CDF.
- R7: A write on rising edge W restarts the timing. No strobe is driven after edge W, and the first strobe is `phase_tick[0]`, driven after edge W + CDF + 1 using the new setting.
- R8: An SCGD value of 63 is stored as 62, so it yields the same period as 62.
- R9: A control byte written while `enable` is low is kept, and it sets the timing once `enable` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; when low, both counters are held cleared |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_data | input | 8 | Control byte: SCGD in [7:2], CDF in [1:0] |
| phase_tick | output | 4 | One-cycle quarter-period strobes; bit k marks the start of quarter k |

## Verification
The bench builds the block with its default widths: a 2-bit prescale field, a 6-bit period field and a ceiling of 62. With these values every prescale ratio can be reached, and so can both ends of the period range, from the shortest period of 20 steps to the longest of 516 steps times 4. The bench also writes the out-of-range value 63 to exercise the ceiling. The same defaults let the bench check the restart latency for each prescale ratio, both on an enable rise and on a write made in the middle of a period.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    parameter int CDF_W       = 2;
    parameter int SCGD_W      = 6;
    parameter int SCGD_LIMIT  = 62;
    parameter int PERIOD_BASE = 20;
    parameter int PERIOD_STEP = 8;
    parameter int NUM_PHASES  = 4;

    localparam int CFG_W      = CDF_W + SCGD_W;
    localparam int PERIOD_MAX = PERIOD_STEP * SCGD_LIMIT + PERIOD_BASE;
    localparam int QTR_STEP   = PERIOD_STEP / NUM_PHASES;
    localparam int QTR_BASE   = PERIOD_BASE / NUM_PHASES;
    localparam int QTR_MAX    = PERIOD_MAX / NUM_PHASES;
    localparam int QTR_W      = $clog2(QTR_MAX + 1);
    localparam int PH_W       = $clog2(NUM_PHASES);

    typedef struct packed {
        logic [SCGD_W-1:0] scgd;
        logic [CDF_W-1:0]  cdf;
    } rate_cfg_t;

endpackage

// File: rtl/scl_rate_cfg.sv
module scl_rate_cfg
    import scl_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] data_i,
    output rate_cfg_t        cfg_o,
    output logic [QTR_W-1:0] qtr_o,
    output logic             restart_o
);

    typedef struct packed {
        rate_cfg_t        cfg;
        logic [QTR_W-1:0] qtr;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    rate_cfg_t  wr_cfg;

    always_comb begin
        st_d   = st_q;
        wr_cfg = rate_cfg_t'(data_i);
        // period select saturates at the ceiling
        if (wr_cfg.scgd > SCGD_W'(SCGD_LIMIT)) begin
            wr_cfg.scgd = SCGD_W'(SCGD_LIMIT);
        end
        if (wr_i) begin
            st_d.cfg = wr_cfg;
            st_d.qtr = QTR_W'(QTR_STEP) * QTR_W'(wr_cfg.scgd) + QTR_W'(QTR_BASE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= '0;
            st_q.qtr <= QTR_W'(QTR_BASE);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o     = st_q.cfg;
    assign qtr_o     = st_q.qtr;
    assign restart_o = wr_i | ~en_i;

endmodule

// File: rtl/scl_prescale.sv
module scl_prescale
    import scl_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CDF_W-1:0] cdf_i,
    output logic             step_o
);

    typedef struct packed {
        logic [CDF_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == cdf_i);
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CDF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = wrap & ~restart_i;

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_rate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart_i,
    input  logic                  step_i,
    input  logic [QTR_W-1:0]      qtr_i,
    output logic [NUM_PHASES-1:0] tick_o
);

    typedef struct packed {
        logic [QTR_W-1:0]      sub;
        logic [PH_W-1:0]       ph;
        logic [NUM_PHASES-1:0] tick;
    } ph_state_t;

    ph_state_t             st_d, st_q;
    logic [NUM_PHASES-1:0] hit;
    logic                  at_edge;

    assign at_edge = step_i && (st_q.sub == '0);

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_hit
        assign hit[k] = at_edge && (st_q.ph == PH_W'(k));
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = '0;
        if (restart_i) begin
            st_d.sub = '0;
            st_d.ph  = '0;
        end else if (step_i) begin
            st_d.tick = hit;
            if (st_q.sub == qtr_i - QTR_W'(1)) begin
                st_d.sub = '0;
                if (st_q.ph == PH_W'(NUM_PHASES - 1)) begin
                    st_d.ph = '0;
                end else begin
                    st_d.ph = st_q.ph + PH_W'(1);
                end
            end else begin
                st_d.sub = st_q.sub + QTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  cfg_wr,
    input  logic [CFG_W-1:0]      cfg_data,
    output logic [NUM_PHASES-1:0] phase_tick
);

    rate_cfg_t        cfg;
    logic [QTR_W-1:0] qtr;
    logic             restart;
    logic             step;

    scl_rate_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (enable),
        .wr_i      (cfg_wr),
        .data_i    (cfg_data),
        .cfg_o     (cfg),
        .qtr_o     (qtr),
        .restart_o (restart)
    );

    scl_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .cdf_i     (cfg.cdf),
        .step_o    (step)
    );

    scl_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .step_i    (step),
        .qtr_i     (qtr),
        .tick_o    (phase_tick)
    );

endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk
    import scl_rate_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic                  cfg_wr,
    input logic [CFG_W-1:0]      cfg_data,
    input logic [NUM_PHASES-1:0] phase_tick
);

    logic [SCGD_W-1:0]     m_scgd;
    logic [CDF_W-1:0]      m_cdf;
    logic                  seen;
    logic [15:0]           gap_cnt;
    logic [NUM_PHASES-1:0] last_tick;
    logic [15:0]           exp_gap;

    // independent model of the strobe spacing from the port-side setting
    assign exp_gap = 16'((2 * int'(m_scgd) + 5) * (int'(m_cdf) + 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_scgd    <= '0;
            m_cdf     <= '0;
            seen      <= 1'b0;
            gap_cnt   <= '0;
            last_tick <= '0;
        end else begin
            if (cfg_wr) begin
                m_cdf  <= cfg_data[CDF_W-1:0];
                m_scgd <= (cfg_data[CFG_W-1:CDF_W] > SCGD_W'(SCGD_LIMIT))
                          ? SCGD_W'(SCGD_LIMIT) : cfg_data[CFG_W-1:CDF_W];
            end
            if (cfg_wr || !enable) begin
                seen    <= 1'b0;
                gap_cnt <= '0;
            end else if (phase_tick != '0) begin
                seen      <= 1'b1;
                gap_cnt   <= 16'd1;
                last_tick <= phase_tick;
            end else begin
                gap_cnt <= gap_cnt + 16'd1;
            end
        end
    end

    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_tick));

    p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase_tick == '0));

    p_quiet_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (phase_tick == '0));

    p_first_is_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick != '0 && !seen && enable && !cfg_wr) |-> phase_tick[0]);

    p_rotation_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick != '0 && seen && enable && !cfg_wr)
            |-> (phase_tick == {last_tick[NUM_PHASES-2:0], last_tick[NUM_PHASES-1]}));

    p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick != '0 && seen && enable && !cfg_wr) |-> (gap_cnt == exp_gap));

endmodule

bind scl_rate_gen scl_rate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_wr     (cfg_wr),
    .cfg_data   (cfg_data),
    .phase_tick (phase_tick)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic [3:0] phase_tick;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_rate_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_wr     (cfg_wr),
        .cfg_data   (cfg_data),
        .phase_tick (phase_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_tick(input int limit, output int idx, output int at);
        idx = -1;
        at  = -1;
        for (int n = 0; n < limit; n++) begin
            @(negedge clk);
            if (phase_tick != 4'b0) begin
                check($countones(phase_tick) == 1, "R5 one strobe per cycle",
                      $countones(phase_tick), 1);
                for (int b = 0; b < 4; b++) if (phase_tick[b]) idx = b;
                at = cyc;
                return;
            end
        end
    endtask

    task automatic count_quiet(input int ncyc, output int seen);
        seen = 0;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            if (phase_tick != 4'b0) seen++;
        end
    endtask

    // R2: SCGD in [7:2], CDF in [1:0]
    task automatic write_cfg(input int cdf, input int scgd);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_data = 8'((scgd << 2) | cdf);
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic t_reset();
        int seen;
        count_quiet(20, seen);
        check(seen == 0, "R1 quiet while in reset", seen, 0);
        @(negedge clk);
        rst_n = 1'b1;
        count_quiet(40, seen);
        check(seen == 0, "R1 quiet after reset with enable low", seen, 0);
    endtask

    // programs a setting while disabled, enables, and measures the strobe train
    task automatic run_cfg(input int cdf, input int scgd, input int eff);
        int g, p, idx, at, t0, prev, k, seen;
        g = (2 * eff + 5) * (cdf + 1);
        p = (8 * eff + 20) * (cdf + 1);
        @(negedge clk);
        enable = 1'b0;
        write_cfg(cdf, scgd);
        count_quiet(10, seen);
        check(seen == 0, "R6 no strobe while disabled", seen, 0);
        @(negedge clk);
        k = cyc;
        enable = 1'b1;
        wait_tick(g + 10, idx, at);
        check(idx == 0, "R9 R6 first strobe is phase 0", idx, 0);
        check(at == k + 1 + cdf, "R6 enable-to-first-strobe latency", at - k, 1 + cdf);
        t0 = at;
        prev = at;
        for (int i = 1; i <= 8; i++) begin
            wait_tick(g + 10, idx, at);
            check(idx == i % 4, "R4 strobe rotation", idx, i % 4);
            check(at - prev == g, "R4 R2 quarter spacing", at - prev, g);
            if (i % 4 == 0)
                check(at - t0 == p * (i / 4), "R3 period", at - t0, p * (i / 4));
            prev = at;
        end
    endtask

    task automatic t_disable();
        int seen, idx, at, k;
        run_cfg(2, 5, 5);
        @(negedge clk);
        enable = 1'b0;
        count_quiet(300, seen);
        check(seen == 0, "R6 enable low stops strobes", seen, 0);
        @(negedge clk);
        k = cyc;
        enable = 1'b1;
        wait_tick(200, idx, at);
        check(idx == 0, "R6 restart after enable is phase 0", idx, 0);
        check(at == k + 3, "R6 counters held cleared", at - k, 3);
    endtask

    task automatic t_restart();
        int idx, at, k, prev;
        run_cfg(3, 20, 20);
        wait_tick(400, idx, at);
        repeat (7) @(negedge clk);
        k = cyc;
        cfg_wr   = 1'b1;
        cfg_data = 8'((2 << 2) | 0);
        @(negedge clk);
        cfg_wr = 1'b0;
        check(phase_tick == 4'b0, "R7 no strobe right after write", int'(phase_tick), 0);
        wait_tick(50, idx, at);
        check(idx == 0, "R7 first strobe after write is phase 0", idx, 0);
        check(at == k + 2, "R7 write-to-first-strobe latency", at - k, 2);
        prev = at;
        wait_tick(50, idx, at);
        check(idx == 1 && at - prev == 9, "R7 new setting in force", at - prev, 9);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog R1..: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        run_cfg(0, 0, 0);
        run_cfg(1, 3, 3);
        run_cfg(3, 10, 10);
        run_cfg(2, 62, 62);
        run_cfg(0, 1, 1);
        run_cfg(1, 63, 62);   // R8 ceiling
        t_disable();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule